// File: doc/BRIEF.md
# Guarded Access Redirection Unit

This unit sits beside one core's load/store address path and decides where each access goes. Normal accesses pass straight through on the fixed address split. Guarded accesses are checked against two small structures at once. The first is a fully associative mapping directory that turns a virtual chunk base into a local scratchpad address. The second is a negative filter that lists chunk bases known to be unmapped on every core. A guarded access that misses both is sent to a central filter directory as a query. The core is stalled until that query is answered. An ACK sends the access on to the cache hierarchy and records the chunk in the filter. A NACK aborts the access, because a remote scratchpad has already serviced it.

The unit also acts as an update-based responder for the other cores. A remote snoop that hits the mapping directory reads or writes the local scratchpad. A snoop that misses is refused. Filter invalidations from the central directory remove the matching filter entry and are acknowledged.

When the core installs a mapping, the unit sends an invalidation to the central directory and stalls the core until that invalidation is acknowledged. Chunk size and alignment come from two mask registers: a base mask applied to the full virtual address and an offset mask applied to the low scratchpad-width bits.

The control state machine has three states. IDLE accepts work. QUERY waits for the central answer. INVAL waits for the invalidation acknowledge. It has four transitions:
- IDLE to INVAL on a mapping write.
- IDLE to QUERY on a guarded access that misses both the directory and the filter.
- QUERY to IDLE on a response.
- INVAL to IDLE on the acknowledge.

Top module: `spm_redirect_unit`

## Requirements
- R1: After reset the unit holds busy, route_valid, qry_valid, inv_valid, snp_rsp_valid and finv_ack low. The masks are base 0xFFFFFF00 and offset 0x00FF. The directory and the filter are empty.
- R2: An access with acc_guarded=0 that is accepted while busy=0 and map_wr=0 gives route_valid one cycle later, with route_kind=0 (normal) and route_addr=acc_pa. This holds even when its chunk is mapped, and no query is raised.
- R3: A guarded access whose chunk base (acc_va AND base mask) hits the directory gives route_kind=1 (scratchpad) one cycle later. Its route_addr is the entry's scratchpad base OR (acc_va[low] AND offset mask), zero-extended.
- R4: A guarded access that misses the directory but hits the filter gives route_kind=2 (cache) with route_addr=acc_pa one cycle later, without a query.
- R5: A guarded access that misses both raises qry_valid the next cycle, with qry_va=acc_va, qry_write and qry_wdata. qry_valid and busy stay high until the cycle rsp_valid is sampled.
- R6: A response with rsp_ack=1 gives route_kind=2 with the stored acc_pa in the next cycle, drops busy, and installs the chunk base in the filter.
- R7: A response with rsp_ack=0 gives route_kind=3 (abort) and installs nothing, so the same chunk queries again.
- R8: cfg_wr loads both masks. All addresses in one chunk share a directory or filter entry.
- R9: A snoop whose chunk hits the directory drives spm_en, spm_we=snp_write, spm_addr and spm_wdata in the same cycle. The next cycle gives snp_rsp_valid=1, snp_rsp_hit=1 and snp_rsp_rdata=spm_rdata.
- R10: A snoop that misses keeps spm_en low and gives snp_rsp_valid=1 with snp_rsp_hit=0 the next cycle.
- R11: map_wr writes entry map_slot at once. The next cycle raises inv_valid with inv_va = map_va AND base mask, and busy. Both stay high until inv_ack is sampled.
- R12: finv_valid removes the filter entry for finv_va's chunk and gives finv_ack the next cycle, so that chunk queries again.
- R13: The filter replaces entries round robin. With depth 16, the seventeenth install evicts the first and keeps the second.
- R14: A directory hit takes priority over a filter hit for the same chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load both mask registers |
| cfg_base_mask | input | VA_W | New chunk-base mask |
| cfg_off_mask | input | SPA_W | New in-chunk offset mask |
| acc_valid | input | 1 | Core access request |
| acc_guarded | input | 1 | Access is guarded |
| acc_write | input | 1 | Access is a store |
| acc_va | input | VA_W | Virtual address |
| acc_pa | input | VA_W | Translated physical address |
| acc_wdata | input | DATA_W | Store data |
| busy | output | 1 | Core must hold its request |
| route_valid | output | 1 | Routing decision pulse |
| route_kind | output | 2 | 0 normal, 1 scratchpad, 2 cache, 3 abort |
| route_addr | output | VA_W | Target address |
| qry_valid | output | 1 | Query to central directory pending |
| qry_va | output | VA_W | Query virtual address |
| qry_write | output | 1 | Query is a store |
| qry_wdata | output | DATA_W | Query store data |
| rsp_valid | input | 1 | Central response |
| rsp_ack | input | 1 | 1 ACK, 0 NACK |
| map_wr | input | 1 | Install a mapping |
| map_slot | input | DIR_IDX_W | Directory slot |
| map_va | input | VA_W | Mapped virtual chunk |
| map_spa | input | SPA_W | Scratchpad base |
| inv_valid | output | 1 | Invalidation request pending |
| inv_va | output | VA_W | Chunk being invalidated |
| inv_ack | input | 1 | Invalidation complete |
| snp_valid | input | 1 | Remote snoop |
| snp_write | input | 1 | Snoop is a store |
| snp_va | input | VA_W | Snoop virtual address |
| snp_wdata | input | DATA_W | Snoop store data |
| snp_rsp_valid | output | 1 | Snoop answer |
| snp_rsp_hit | output | 1 | 1 serviced, 0 NACK |
| snp_rsp_rdata | output | DATA_W | Snoop load data |
| spm_en | output | 1 | Scratchpad access |
| spm_we | output | 1 | Scratchpad write |
| spm_addr | output | SPA_W | Scratchpad address |
| spm_wdata | output | DATA_W | Scratchpad write data |
| spm_rdata | input | DATA_W | Scratchpad read data, one cycle after spm_en |
| finv_valid | input | 1 | Filter invalidation |
| finv_va | input | VA_W | Chunk to drop |
| finv_ack | output | 1 | Filter invalidation done |

## Verification
The bench probes three faults.
- Filter installed on a NACK: the same chunk would route straight to the cache instead of querying again. The bench repeats such an access to catch this.
- Priority between the two structures inverted: a chunk held in both the filter and the directory would go to the cache instead of the scratchpad. The bench places one chunk in both.
- Round-robin pointer fault: filling the filter past its depth exposes a pointer that does not advance or wraps wrongly, because the wrong victim is evicted.

Snoops are checked at the scratchpad port in the request cycle and at the response one cycle later. This catches a unit that touches the scratchpad on a miss or answers a miss as a hit. Stall behaviour is checked by holding the responses back for several cycles.

// File: rtl/spm_redir_pkg.sv
package spm_redir_pkg;
    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_SPM    = 2'd1,
        RT_CACHE  = 2'd2,
        RT_ABORT  = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUERY = 2'd1,
        ST_INVAL = 2'd2
    } state_e;
endpackage

// File: rtl/spm_map_dir.sv
module spm_map_dir #(
    parameter int VA_W  = 32,
    parameter int SPA_W = 16,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [VA_W-1:0]  wr_base,
    input  logic [SPA_W-1:0] wr_spa,
    input  logic [VA_W-1:0]  a_base,
    output logic             a_hit,
    output logic [SPA_W-1:0] a_spa,
    input  logic [VA_W-1:0]  b_base,
    output logic             b_hit,
    output logic [SPA_W-1:0] b_spa
);
    logic [DEPTH-1:0] a_match;
    logic [DEPTH-1:0] b_match;
    logic [SPA_W-1:0] a_sel [DEPTH];
    logic [SPA_W-1:0] b_sel [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic             vld_q;
        logic [VA_W-1:0]  base_q;
        logic [SPA_W-1:0] spa_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                base_q <= '0;
                spa_q  <= '0;
            end else if (wr_en && wr_slot == IDX_W'(i)) begin
                vld_q  <= 1'b1;
                base_q <= wr_base;
                spa_q  <= wr_spa;
            end
        end
        assign a_match[i] = vld_q && (base_q == a_base);
        assign b_match[i] = vld_q && (base_q == b_base);
        assign a_sel[i]   = a_match[i] ? spa_q : '0;
        assign b_sel[i]   = b_match[i] ? spa_q : '0;
    end

    always_comb begin
        a_spa = '0;
        b_spa = '0;
        for (int i = 0; i < DEPTH; i++) begin
            a_spa = a_spa | a_sel[i];
            b_spa = b_spa | b_sel[i];
        end
    end

    assign a_hit = |a_match;
    assign b_hit = |b_match;
endmodule

// File: rtl/spm_neg_filter.sv
module spm_neg_filter #(
    parameter int VA_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] look_base,
    output logic            hit,
    input  logic            ins_en,
    input  logic [VA_W-1:0] ins_base,
    input  logic            clr_en,
    input  logic [VA_W-1:0] clr_base
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [DEPTH-1:0] hits;
    logic             ins_ok;

    // an invalidation of the same chunk in the same cycle wins over the install
    assign ins_ok = ins_en && !(clr_en && clr_base == ins_base);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic            vld_q;
        logic [VA_W-1:0] base_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                base_q <= '0;
            end else if (ins_ok && ptr_q == IDX_W'(i)) begin
                vld_q  <= 1'b1;
                base_q <= ins_base;
            end else if (clr_en && base_q == clr_base) begin
                vld_q  <= 1'b0;
            end
        end
        assign hits[i] = vld_q && (base_q == look_base);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ins_ok)
            ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end

    assign hit = |hits;
endmodule

// File: rtl/spm_redirect_unit.sv
module spm_redirect_unit
    import spm_redir_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int DATA_W    = 32,
    parameter int SPA_W     = 16,
    parameter int DIR_DEPTH = 8,
    parameter int FLT_DEPTH = 16,
    parameter int CHUNK_LG  = 8,
    localparam int DIR_IDX_W = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [VA_W-1:0]      cfg_base_mask,
    input  logic [SPA_W-1:0]     cfg_off_mask,
    input  logic                 acc_valid,
    input  logic                 acc_guarded,
    input  logic                 acc_write,
    input  logic [VA_W-1:0]      acc_va,
    input  logic [VA_W-1:0]      acc_pa,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic                 busy,
    output logic                 route_valid,
    output logic [1:0]           route_kind,
    output logic [VA_W-1:0]      route_addr,
    output logic                 qry_valid,
    output logic [VA_W-1:0]      qry_va,
    output logic                 qry_write,
    output logic [DATA_W-1:0]    qry_wdata,
    input  logic                 rsp_valid,
    input  logic                 rsp_ack,
    input  logic                 map_wr,
    input  logic [DIR_IDX_W-1:0] map_slot,
    input  logic [VA_W-1:0]      map_va,
    input  logic [SPA_W-1:0]     map_spa,
    output logic                 inv_valid,
    output logic [VA_W-1:0]      inv_va,
    input  logic                 inv_ack,
    input  logic                 snp_valid,
    input  logic                 snp_write,
    input  logic [VA_W-1:0]      snp_va,
    input  logic [DATA_W-1:0]    snp_wdata,
    output logic                 snp_rsp_valid,
    output logic                 snp_rsp_hit,
    output logic [DATA_W-1:0]    snp_rsp_rdata,
    output logic                 spm_en,
    output logic                 spm_we,
    output logic [SPA_W-1:0]     spm_addr,
    output logic [DATA_W-1:0]    spm_wdata,
    input  logic [DATA_W-1:0]    spm_rdata,
    input  logic                 finv_valid,
    input  logic [VA_W-1:0]      finv_va,
    output logic                 finv_ack
);
    localparam logic [SPA_W-1:0] RST_OFF_MASK  = SPA_W'((1 << CHUNK_LG) - 1);
    localparam logic [VA_W-1:0]  RST_BASE_MASK = ~VA_W'((1 << CHUNK_LG) - 1);

    state_e              state_q, state_d;
    logic [VA_W-1:0]     base_mask_q;
    logic [SPA_W-1:0]    off_mask_q;
    logic [VA_W-1:0]     hold_va_q, hold_pa_q;
    logic                hold_wr_q;
    logic [DATA_W-1:0]   hold_wdata_q;
    logic                route_valid_q;
    route_e              route_kind_q;
    logic [VA_W-1:0]     route_addr_q;
    logic                snp_rsp_valid_q, snp_rsp_hit_q, finv_ack_q;

    logic [VA_W-1:0]     acc_base, snp_base, hold_base;
    logic                dir_hit, flt_hit, snp_hit;
    logic [SPA_W-1:0]    dir_spa, snp_spa;
    logic                take_map, take_acc, flt_ins;

    assign acc_base  = acc_va & base_mask_q;
    assign snp_base  = snp_va & base_mask_q;
    assign hold_base = hold_va_q & base_mask_q;
    assign take_map  = (state_q == ST_IDLE) && map_wr;
    assign take_acc  = (state_q == ST_IDLE) && !map_wr && acc_valid;
    assign flt_ins   = (state_q == ST_QUERY) && rsp_valid && rsp_ack;

    spm_map_dir #(.VA_W(VA_W), .SPA_W(SPA_W), .DEPTH(DIR_DEPTH)) i_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_map),
        .wr_slot (map_slot),
        .wr_base (map_va & base_mask_q),
        .wr_spa  (map_spa),
        .a_base  (acc_base),
        .a_hit   (dir_hit),
        .a_spa   (dir_spa),
        .b_base  (snp_base),
        .b_hit   (snp_hit),
        .b_spa   (snp_spa)
    );

    spm_neg_filter #(.VA_W(VA_W), .DEPTH(FLT_DEPTH)) i_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_base (acc_base),
        .hit       (flt_hit),
        .ins_en    (flt_ins),
        .ins_base  (hold_base),
        .clr_en    (finv_valid),
        .clr_base  (finv_va & base_mask_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_map)
                    state_d = ST_INVAL;
                else if (take_acc && acc_guarded && !dir_hit && !flt_hit)
                    state_d = ST_QUERY;
            end
            ST_QUERY: if (rsp_valid) state_d = ST_IDLE;
            ST_INVAL: if (inv_ack)   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // held request, masks and registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_mask_q     <= RST_BASE_MASK;
            off_mask_q      <= RST_OFF_MASK;
            hold_va_q       <= '0;
            hold_pa_q       <= '0;
            hold_wr_q       <= 1'b0;
            hold_wdata_q    <= '0;
            route_valid_q   <= 1'b0;
            route_kind_q    <= RT_NORMAL;
            route_addr_q    <= '0;
            snp_rsp_valid_q <= 1'b0;
            snp_rsp_hit_q   <= 1'b0;
            finv_ack_q      <= 1'b0;
        end else begin
            route_valid_q   <= 1'b0;
            snp_rsp_valid_q <= snp_valid;
            snp_rsp_hit_q   <= snp_valid && snp_hit;
            finv_ack_q      <= finv_valid;
            if (cfg_wr) begin
                base_mask_q <= cfg_base_mask;
                off_mask_q  <= cfg_off_mask;
            end
            if (take_map)
                hold_va_q <= map_va;
            if (take_acc) begin
                hold_va_q    <= acc_va;
                hold_pa_q    <= acc_pa;
                hold_wr_q    <= acc_write;
                hold_wdata_q <= acc_wdata;
                if (!acc_guarded) begin
                    route_valid_q <= 1'b1;
                    route_kind_q  <= RT_NORMAL;
                    route_addr_q  <= acc_pa;
                end else if (dir_hit) begin
                    route_valid_q <= 1'b1;
                    route_kind_q  <= RT_SPM;
                    route_addr_q  <= VA_W'(dir_spa | (acc_va[SPA_W-1:0] & off_mask_q));
                end else if (flt_hit) begin
                    route_valid_q <= 1'b1;
                    route_kind_q  <= RT_CACHE;
                    route_addr_q  <= acc_pa;
                end
            end
            if (state_q == ST_QUERY && rsp_valid) begin
                route_valid_q <= 1'b1;
                route_kind_q  <= rsp_ack ? RT_CACHE : RT_ABORT;
                route_addr_q  <= hold_pa_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        qry_valid     = (state_q == ST_QUERY);
        inv_valid     = (state_q == ST_INVAL);
        qry_va        = hold_va_q;
        qry_write     = hold_wr_q;
        qry_wdata     = hold_wdata_q;
        inv_va        = hold_base;
        route_valid   = route_valid_q;
        route_kind    = route_kind_q;
        route_addr    = route_addr_q;
        spm_en        = snp_valid && snp_hit;
        spm_we        = snp_valid && snp_hit && snp_write;
        spm_addr      = snp_spa | (snp_va[SPA_W-1:0] & off_mask_q);
        spm_wdata     = snp_wdata;
        snp_rsp_valid = snp_rsp_valid_q;
        snp_rsp_hit   = snp_rsp_hit_q;
        snp_rsp_rdata = spm_rdata;
        finv_ack      = finv_ack_q;
    end
endmodule

// File: rtl/spm_redirect_unit_chk.sv
module spm_redirect_unit_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            acc_guarded,
    input logic [VA_W-1:0] acc_pa,
    input logic            map_wr,
    input logic            busy,
    input logic            route_valid,
    input logic [1:0]      route_kind,
    input logic [VA_W-1:0] route_addr,
    input logic            qry_valid,
    input logic            rsp_valid,
    input logic            rsp_ack,
    input logic            inv_valid,
    input logic            inv_ack,
    input logic            snp_valid,
    input logic            snp_rsp_valid,
    input logic            snp_rsp_hit,
    input logic            spm_en,
    input logic            finv_valid,
    input logic            finv_ack
);
    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_guarded && !busy && !map_wr |=>
        route_valid && route_kind == 2'd0 && route_addr == $past(acc_pa)); // R2
    AST_QRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid && !rsp_valid |=> qry_valid && busy); // R5
    AST_ACK_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid && rsp_valid && rsp_ack |=> route_valid && route_kind == 2'd2 && !busy); // R6
    AST_NACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid && rsp_valid && !rsp_ack |=> route_valid && route_kind == 2'd3 && !busy); // R7
    AST_SNP_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && spm_en |=> snp_rsp_valid && snp_rsp_hit); // R9
    AST_SNP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !spm_en |=> snp_rsp_valid && !snp_rsp_hit); // R10
    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ack |=> inv_valid && busy); // R11
    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && qry_valid)); // R11
    AST_FINV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        finv_valid |=> finv_ack); // R12
endmodule

bind spm_redirect_unit spm_redirect_unit_chk #(.VA_W(VA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_guarded   (acc_guarded),
    .acc_pa        (acc_pa),
    .map_wr        (map_wr),
    .busy          (busy),
    .route_valid   (route_valid),
    .route_kind    (route_kind),
    .route_addr    (route_addr),
    .qry_valid     (qry_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ack       (rsp_ack),
    .inv_valid     (inv_valid),
    .inv_ack       (inv_ack),
    .snp_valid     (snp_valid),
    .snp_rsp_valid (snp_rsp_valid),
    .snp_rsp_hit   (snp_rsp_hit),
    .spm_en        (spm_en),
    .finv_valid    (finv_valid),
    .finv_ack      (finv_ack)
);

// File: tb/test_spm_redirect_unit.sv
`timescale 1ns/100ps
module test_spm_redirect_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0;
    logic [31:0] cfg_base_mask = '0;
    logic [15:0] cfg_off_mask = '0;
    logic        acc_valid = 0, acc_guarded = 0, acc_write = 0;
    logic [31:0] acc_va = '0, acc_pa = '0, acc_wdata = '0;
    logic        busy, route_valid, qry_valid, qry_write, inv_valid;
    logic [1:0]  route_kind;
    logic [31:0] route_addr, qry_va, qry_wdata, inv_va;
    logic        rsp_valid = 0, rsp_ack = 0, map_wr = 0, inv_ack = 0;
    logic [2:0]  map_slot = '0;
    logic [31:0] map_va = '0;
    logic [15:0] map_spa = '0;
    logic        snp_valid = 0, snp_write = 0;
    logic [31:0] snp_va = '0, snp_wdata = '0;
    logic        snp_rsp_valid, snp_rsp_hit, spm_en, spm_we, finv_ack;
    logic [31:0] snp_rsp_rdata, spm_wdata;
    logic [31:0] spm_rdata = '0;
    logic [15:0] spm_addr;
    logic        finv_valid = 0;
    logic [31:0] finv_va = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spm_redirect_unit i_spm_redirect_unit (.*);

    // scratchpad model: read data is a pattern of the address, one cycle later
    always @(posedge clk)
        if (spm_en && !spm_we) spm_rdata <= {spm_addr, ~spm_addr};

    typedef struct packed {
        logic        g;
        logic        w;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  rsp;   // 0 none expected, 1 ACK, 2 NACK
        logic [1:0]  kind;
        logic [31:0] addr;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 32'h1000_0010, 32'h0000_5010, 2'd0, 2'd0, 32'h0000_5010}, // R2 normal on mapped chunk
        '{1'b1, 1'b0, 32'h1000_0123, 32'h0000_9123, 2'd0, 2'd1, 32'h0000_2123}, // R3 directory hit
        '{1'b1, 1'b0, 32'h3000_0040, 32'h0007_0040, 2'd1, 2'd2, 32'h0007_0040}, // R5 R6 query ACK
        '{1'b1, 1'b0, 32'h3000_0F00, 32'h0007_0F00, 2'd0, 2'd2, 32'h0007_0F00}, // R4 R8 same chunk filter hit
        '{1'b1, 1'b1, 32'h4000_0008, 32'h0000_8008, 2'd2, 2'd3, 32'h0000_8008}, // R7 NACK abort
        '{1'b1, 1'b0, 32'h4000_0008, 32'h0000_8008, 2'd1, 2'd2, 32'h0000_8008}, // R7 queried again
        '{1'b1, 1'b0, 32'h4000_0FFC, 32'h0000_8FFC, 2'd0, 2'd2, 32'h0000_8FFC}  // R6 installed
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 route_valid", 32'(route_valid), 0);
        chk("R1 qry_valid", 32'(qry_valid), 0);
        chk("R1 inv_valid", 32'(inv_valid), 0);
        chk("R1 snp_rsp_valid", 32'(snp_rsp_valid), 0);
        chk("R1 finv_ack", 32'(finv_ack), 0);
    endtask

    task automatic access(string tag, logic g, logic w, logic [31:0] va, logic [31:0] pa,
                          logic [1:0] rsp, logic [1:0] kind, logic [31:0] addr);
        acc_valid = 1; acc_guarded = g; acc_write = w; acc_va = va; acc_pa = pa;
        acc_wdata = va ^ 32'hA5A5_A5A5;
        @(negedge clk);
        acc_valid = 0;
        if (rsp != 2'd0) begin
            chk({tag, " qry_valid"}, 32'(qry_valid), 1);
            chk({tag, " qry_va"}, qry_va, va);
            chk({tag, " qry_write"}, 32'(qry_write), 32'(w));
            chk({tag, " qry_wdata"}, qry_wdata, va ^ 32'hA5A5_A5A5);
            @(negedge clk);
            chk({tag, " busy held"}, 32'(busy), 1);     // R5
            rsp_valid = 1; rsp_ack = (rsp == 2'd1);
            @(negedge clk);
            rsp_valid = 0;
            chk({tag, " busy drop"}, 32'(busy), 0);
        end else begin
            chk({tag, " no query"}, 32'(qry_valid), 0);
        end
        chk({tag, " route_valid"}, 32'(route_valid), 1);
        chk({tag, " route_kind"}, 32'(route_kind), 32'(kind));
        chk({tag, " route_addr"}, route_addr, addr);
    endtask

    task automatic do_map(logic [2:0] slot, logic [31:0] va, logic [15:0] spa, logic [31:0] base);
        map_wr = 1; map_slot = slot; map_va = va; map_spa = spa;
        @(negedge clk);
        map_wr = 0;
        chk("R11 inv_valid", 32'(inv_valid), 1);
        chk("R11 inv_va", inv_va, base);
        chk("R11 busy", 32'(busy), 1);
        @(negedge clk);
        chk("R11 inv held", 32'(inv_valid), 1);
        inv_ack = 1;
        @(negedge clk);
        inv_ack = 0;
        chk("R11 inv done", 32'(inv_valid), 0);
    endtask

    task automatic snoop(string tag, logic w, logic [31:0] va, logic [31:0] wd,
                         logic hit, logic [15:0] addr);
        snp_valid = 1; snp_write = w; snp_va = va; snp_wdata = wd;
        #1;
        chk({tag, " spm_en"}, 32'(spm_en), 32'(hit));
        if (hit) begin
            chk({tag, " spm_we"}, 32'(spm_we), 32'(w));
            chk({tag, " spm_addr"}, 32'(spm_addr), 32'(addr));
            if (w) chk({tag, " spm_wdata"}, spm_wdata, wd);
        end
        @(negedge clk);
        snp_valid = 0;
        chk({tag, " rsp_valid"}, 32'(snp_rsp_valid), 1);
        chk({tag, " rsp_hit"}, 32'(snp_rsp_hit), 32'(hit));
        if (hit && !w) chk({tag, " rdata"}, snp_rsp_rdata, {addr, ~addr});
    endtask

    function automatic string vec_tag(vec_t v);
        if (v.rsp == 2'd2) return "R7";
        if (v.rsp == 2'd1) return "R6";
        if (v.kind == 2'd0) return "R2";
        if (v.kind == 2'd1) return "R3";
        return "R4";
    endfunction

    initial begin
        do_reset();
        // R8: switch to 4 KiB chunks
        cfg_wr = 1; cfg_base_mask = 32'hFFFF_F000; cfg_off_mask = 16'h0FFF;
        @(negedge clk);
        cfg_wr = 0;
        do_map(3'd0, 32'h1000_0ABC, 16'h2000, 32'h1000_0000);

        for (int k = 0; k < 7; k++)
            access(vec_tag(VECS[k]), VECS[k].g, VECS[k].w, VECS[k].va, VECS[k].pa,
                   VECS[k].rsp, VECS[k].kind, VECS[k].addr);

        // R14: chunk 0x3000_0000 is in the filter, now also mapped
        do_map(3'd1, 32'h3000_0000, 16'h4000, 32'h3000_0000);
        access("R14", 1, 0, 32'h3000_0010, 32'h0007_0010, 2'd0, 2'd1, 32'h0000_4010);

        // R12: drop chunk 0x4000_0000 from the filter
        finv_valid = 1; finv_va = 32'h4000_0ABC;
        @(negedge clk);
        finv_valid = 0;
        chk("R12 finv_ack", 32'(finv_ack), 1);
        access("R12", 1, 0, 32'h4000_0020, 32'h0000_8020, 2'd1, 2'd2, 32'h0000_8020);

        snoop("R9 read", 0, 32'h1000_0044, 32'h0, 1, 16'h2044);
        snoop("R9 write", 1, 32'h1000_0048, 32'hDEAD_BEEF, 1, 16'h2048);
        snoop("R10", 0, 32'h5000_0000, 32'h0, 0, 16'h0);

        // R13: reset restores 256-byte chunks (R1); fill filter past depth
        do_reset();
        for (int i = 0; i <= 16; i++)
            access("R13 fill", 1, 0, 32'h6000_0000 + 32'(i << 8), 32'(i), 2'd1, 2'd2, 32'(i));
        access("R13 kept", 1, 0, 32'h6000_0110, 32'h11, 2'd0, 2'd2, 32'h11);
        access("R13 evicted", 1, 0, 32'h6000_0010, 32'h10, 2'd1, 2'd2, 32'h10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule